// File: doc/BRIEF.md
# GPIO Port with Per-Pin Function Mux

This block is a 16-pin general-purpose I/O port. Each pin is either a plain GPIO, driven from an output data latch and a direction bit, or is handed over to one of four peripheral sources. A 2-bit selector per pin picks the source. In peripheral mode, the selected source's output value and output enable drive the pin.

Software reaches the port over a simple register bus. Output data and direction are never written whole. They change only through set and clear addresses, where a 1 in a write bit touches that pin alone. This lets separate agents change separate pins without a read-modify-write. A level register returns what each pin currently shows. An input enable per pin gates whether an input pin's level can be read at all.

Writes take effect at the clock edge. Reads are combinational from the current state and the pin inputs.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset, every pin has its output enable low, and the function enable, mux, direction, output data and input enable registers all read 0.
- R2: A write to address 3 sets each output data bit whose write bit is 1 and leaves the others unchanged. Reading address 3 or 4 returns the output data latch.
- R3: A write to address 4 clears each output data bit whose write bit is 1 and leaves the others unchanged.
- R4: A write to address 5 makes each pin whose write bit is 1 an output. A write to address 6 makes each such pin an input. Reading either address returns the direction bits, where 1 means output.
- R5: A pin whose function enable bit (address 0) is 0 is in GPIO mode. Its output enable equals its direction bit and its output value equals its output data bit. For a GPIO output, the level register (address 2) returns the driven data bit.
- R6: For a pin that is not a GPIO output, the level register bit returns the pin input when its input enable bit (address 7) is 1, and returns 0 when that bit is 0.
- R7: A pin whose function enable bit is 1 takes its output value and output enable from the peripheral source chosen by its selector field.
- R8: The mux register at address 1 is 32 bits wide and reads back as written. The selector of pin p sits at bits [2p+1:2p], and each pin's field acts on that pin only.
- R9: The pin input forwarded to the peripherals equals the pin input for pins in peripheral mode and 0 for pins in GPIO mode.
- R10: Writes to the level address (2) and to unmapped addresses (8 to 15) change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_i | input | 16 | Pin input levels |
| pin_o | output | 16 | Pin output values |
| pin_oe | output | 16 | Pin output enables |
| periph_out_i | input | 4x16 | Output value of each peripheral source, indexed [source][pin] |
| periph_oe_i | input | 4x16 | Output enable of each peripheral source, indexed [source][pin] |
| periph_in_o | output | 16 | Pin input forwarded to peripherals |

## Verification
The assertions assume that the bus strobe and address are known and settled at each clock edge. They also assume that a write is a single-cycle pulse, so the set and clear checks see the register one cycle after the strobe. The bench drives every input on the falling edge and holds each write for exactly one rising edge. It then reads back after the write has landed. Pin and peripheral inputs change only between register accesses.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
    localparam int PINS  = 16;
    localparam int NFUNC = 4;
    localparam int SELW  = $clog2(NFUNC);
    localparam int ADDRW = 4;
    localparam int BUSW  = 32;
    localparam int MUXW  = PINS * SELW;

    localparam logic [ADDRW-1:0] ADR_FUNC  = 4'd0;
    localparam logic [ADDRW-1:0] ADR_MUX   = 4'd1;
    localparam logic [ADDRW-1:0] ADR_LEVEL = 4'd2;
    localparam logic [ADDRW-1:0] ADR_DSET  = 4'd3;
    localparam logic [ADDRW-1:0] ADR_DCLR  = 4'd4;
    localparam logic [ADDRW-1:0] ADR_OSET  = 4'd5;
    localparam logic [ADDRW-1:0] ADR_OCLR  = 4'd6;
    localparam logic [ADDRW-1:0] ADR_INEN  = 4'd7;

    typedef enum logic {MODE_GPIO = 1'b0, MODE_PERIPH = 1'b1} pin_mode_e;

    typedef struct packed {
        logic [PINS-1:0] func_en;
        logic [MUXW-1:0] mux;
        logic [PINS-1:0] dir;
        logic [PINS-1:0] dout;
        logic [PINS-1:0] in_en;
    } port_cfg_t;

    function automatic logic [SELW-1:0] sel_of(input logic [MUXW-1:0] m, input int p);
        return m[p*SELW +: SELW];
    endfunction
endpackage

// File: rtl/gpio_mux_regs.sv
module gpio_mux_regs
    import gpio_mux_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [ADDRW-1:0] addr,
    input  logic [BUSW-1:0]  wdata,
    output port_cfg_t        cfg
);
    logic [PINS-1:0] wbits;
    assign wbits = wdata[PINS-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr) begin
            case (addr)
                ADR_FUNC: cfg.func_en <= wbits;
                ADR_MUX:  cfg.mux     <= wdata[MUXW-1:0];
                ADR_DSET: cfg.dout    <= cfg.dout | wbits;
                ADR_DCLR: cfg.dout    <= cfg.dout & ~wbits;
                ADR_OSET: cfg.dir     <= cfg.dir | wbits;
                ADR_OCLR: cfg.dir     <= cfg.dir & ~wbits;
                ADR_INEN: cfg.in_en   <= wbits;
                default:  ;
            endcase
        end
    end

    // R2: written ones land, other bits hold
    p_dset_r2: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == ADR_DSET) |=>
            cfg.dout == ($past(cfg.dout) | $past(wbits)));
    // R3
    p_dclr_r3: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == ADR_DCLR) |=>
            ((cfg.dout & $past(wbits)) == '0) &&
            ((cfg.dout & ~$past(wbits)) == ($past(cfg.dout) & ~$past(wbits))));
    // R4
    p_dir_r4: assert property (@(posedge clk) disable iff (rst)
        (wr && (addr == ADR_OSET || addr == ADR_OCLR)) |=>
            ((cfg.dir & ~$past(wbits)) == ($past(cfg.dir) & ~$past(wbits))));
    // R10: ignored addresses leave all state unchanged
    p_ignore_r10: assert property (@(posedge clk) disable iff (rst)
        (wr && (addr == ADR_LEVEL || addr > ADR_INEN)) |=> $stable(cfg));
endmodule

// File: rtl/gpio_mux_pinsel.sv
module gpio_mux_pinsel
    import gpio_mux_pkg::*;
(
    input  port_cfg_t                   cfg,
    input  logic [PINS-1:0]             pin_i,
    input  logic [NFUNC-1:0][PINS-1:0]  periph_out_i,
    input  logic [NFUNC-1:0][PINS-1:0]  periph_oe_i,
    output logic [PINS-1:0]             pin_o,
    output logic [PINS-1:0]             pin_oe,
    output logic [PINS-1:0]             periph_in_o
);
    for (genvar p = 0; p < PINS; p++) begin : g_pin
        pin_mode_e       mode;
        logic [SELW-1:0] sel;
        assign mode = pin_mode_e'(cfg.func_en[p]);
        assign sel  = sel_of(cfg.mux, p);

        always_comb begin
            if (mode == MODE_PERIPH) begin
                pin_o[p]       = periph_out_i[sel][p];
                pin_oe[p]      = periph_oe_i[sel][p];
                periph_in_o[p] = pin_i[p];
            end else begin
                pin_o[p]       = cfg.dout[p];
                pin_oe[p]      = cfg.dir[p];
                periph_in_o[p] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/gpio_mux_readback.sv
module gpio_mux_readback
    import gpio_mux_pkg::*;
(
    input  port_cfg_t        cfg,
    input  logic [ADDRW-1:0] addr,
    input  logic [PINS-1:0]  pin_i,
    output logic [BUSW-1:0]  rdata
);
    logic [PINS-1:0] gpio_drv;
    logic [PINS-1:0] level;

    assign gpio_drv = ~cfg.func_en & cfg.dir;
    assign level    = (gpio_drv & cfg.dout) | (~gpio_drv & cfg.in_en & pin_i);

    always_comb begin
        rdata = '0;
        case (addr)
            ADR_FUNC:            rdata[PINS-1:0] = cfg.func_en;
            ADR_MUX:             rdata[MUXW-1:0] = cfg.mux;
            ADR_LEVEL:           rdata[PINS-1:0] = level;
            ADR_DSET, ADR_DCLR:  rdata[PINS-1:0] = cfg.dout;
            ADR_OSET, ADR_OCLR:  rdata[PINS-1:0] = cfg.dir;
            ADR_INEN:            rdata[PINS-1:0] = cfg.in_en;
            default:             rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
    import gpio_mux_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bus_wr,
    input  logic [ADDRW-1:0]            bus_addr,
    input  logic [BUSW-1:0]             bus_wdata,
    output logic [BUSW-1:0]             bus_rdata,
    input  logic [PINS-1:0]             pin_i,
    output logic [PINS-1:0]             pin_o,
    output logic [PINS-1:0]             pin_oe,
    input  logic [NFUNC-1:0][PINS-1:0]  periph_out_i,
    input  logic [NFUNC-1:0][PINS-1:0]  periph_oe_i,
    output logic [PINS-1:0]             periph_in_o
);
    port_cfg_t cfg;

    gpio_mux_regs u_regs (
        .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .cfg(cfg)
    );

    gpio_mux_pinsel u_pinsel (
        .cfg(cfg), .pin_i(pin_i), .periph_out_i(periph_out_i),
        .periph_oe_i(periph_oe_i), .pin_o(pin_o), .pin_oe(pin_oe),
        .periph_in_o(periph_in_o)
    );

    gpio_mux_readback u_rb (
        .cfg(cfg), .addr(bus_addr), .pin_i(pin_i), .rdata(bus_rdata)
    );

    // R1: first cycle out of reset, no pin is driven
    p_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_oe == '0 && periph_in_o == '0));
    // R6: level bits of input-disabled non-driving pins read 0
    p_level_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADR_LEVEL) |->
            ((bus_rdata[PINS-1:0] & ~cfg.in_en & ~pin_oe & ~cfg.func_en) == '0));
endmodule

// File: tb/gpio_mux_port_tb.sv
module gpio_mux_port_tb_top;
    import gpio_mux_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst;
    logic bus_wr;
    logic [ADDRW-1:0] bus_addr;
    logic [BUSW-1:0]  bus_wdata;
    logic [BUSW-1:0]  bus_rdata;
    logic [PINS-1:0]  pin_i, pin_o, pin_oe, periph_in_o;
    logic [NFUNC-1:0][PINS-1:0] periph_out_i, periph_oe_i;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_mux_port dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_i(pin_i),
        .pin_o(pin_o), .pin_oe(pin_oe), .periph_out_i(periph_out_i),
        .periph_oe_i(periph_oe_i), .periph_in_o(periph_in_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDRW-1:0] a, input logic [BUSW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [ADDRW-1:0] a, output logic [BUSW-1:0] d);
        @(negedge clk);
        bus_addr = a;
        #(CLK_PERIOD/4);
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [BUSW-1:0] d;
        bus_read(ADR_FUNC, d);  check("R1 func_en", d, 0);
        bus_read(ADR_MUX, d);   check("R1 mux", d, 0);
        bus_read(ADR_OSET, d);  check("R1 dir", d, 0);
        bus_read(ADR_DSET, d);  check("R1 dout", d, 0);
        bus_read(ADR_INEN, d);  check("R1 in_en", d, 0);
        check("R1 pin_oe", {16'h0, pin_oe}, 0);
    endtask

    task automatic t_data_set_clear();
        logic [BUSW-1:0] d;
        bus_write(ADR_DSET, 32'h00F0);
        bus_read(ADR_DSET, d); check("R2 set first", d, 32'h00F0);
        bus_write(ADR_DSET, 32'h0003);
        bus_read(ADR_DCLR, d); check("R2 set keeps others", d, 32'h00F3);
        bus_write(ADR_DCLR, 32'h0030);
        bus_read(ADR_DSET, d); check("R3 clear selected", d, 32'h00C3);
        bus_write(ADR_DCLR, 32'h0000);
        bus_read(ADR_DSET, d); check("R3 clear zero no effect", d, 32'h00C3);
    endtask

    task automatic t_direction();
        logic [BUSW-1:0] d;
        bus_write(ADR_OSET, 32'h00FF);
        bus_read(ADR_OSET, d); check("R4 dir set", d, 32'h00FF);
        bus_write(ADR_OCLR, 32'h000F);
        bus_read(ADR_OCLR, d); check("R4 dir clear", d, 32'h00F0);
    endtask

    task automatic t_gpio_out();
        logic [BUSW-1:0] d;
        pin_i = 16'h0000;
        bus_read(ADR_LEVEL, d);
        check("R5 pin_oe", {16'h0, pin_oe}, 32'h00F0);
        check("R5 pin_o", {16'h0, pin_o}, 32'h00C3);
        check("R5 level readback", d, 32'h00C0);
    endtask

    task automatic t_gpio_in();
        logic [BUSW-1:0] d;
        pin_i = 16'hA50F;
        bus_write(ADR_INEN, 32'hFF00);
        bus_read(ADR_LEVEL, d);
        check("R6 enabled inputs and gated bits", d, 32'hA5C0);
        bus_write(ADR_INEN, 32'hFF0F);
        bus_read(ADR_LEVEL, d);
        check("R6 low inputs enabled", d, 32'hA5CF);
        bus_write(ADR_INEN, 32'hFF00);
    endtask

    task automatic t_periph();
        logic [BUSW-1:0] d;
        periph_out_i[0] = 16'hFFFF; periph_oe_i[0] = 16'h0000;
        periph_out_i[1] = 16'hFFFF; periph_oe_i[1] = 16'h0000;
        periph_out_i[2] = 16'h0001; periph_oe_i[2] = 16'h0001;
        periph_out_i[3] = 16'h0000; periph_oe_i[3] = 16'h0002;
        bus_write(ADR_FUNC, 32'h0003);
        bus_write(ADR_MUX, 32'h0000_000E);
        bus_read(ADR_MUX, d);
        check("R8 mux readback", d, 32'h0000_000E);
        check("R7 pin_oe periph", {16'h0, pin_oe}, 32'h00F3);
        check("R7 pin_o periph", {16'h0, pin_o}, 32'h00C1);
        check("R9 periph_in", {16'h0, periph_in_o}, 32'h0003);
        bus_write(ADR_MUX, 32'hC000_0000);
        bus_read(ADR_MUX, d);
        check("R8 top field readback", d, 32'hC000_0000);
        check("R8 pin_oe source 0", {16'h0, pin_oe}, 32'h00F0);
        check("R8 pin_o source 0", {16'h0, pin_o}, 32'h00C3);
    endtask

    task automatic t_ignored();
        logic [BUSW-1:0] d;
        bus_write(ADR_LEVEL, 32'hFFFF_FFFF);
        bus_write(4'd9, 32'hFFFF_FFFF);
        bus_write(4'd15, 32'h0000_0000);
        bus_read(ADR_DSET, d); check("R10 dout kept", d, 32'h00C3);
        bus_read(ADR_OSET, d); check("R10 dir kept", d, 32'h00F0);
        bus_read(ADR_FUNC, d); check("R10 func kept", d, 32'h0003);
        bus_read(ADR_INEN, d); check("R10 in_en kept", d, 32'hFF00);
        bus_read(4'd9, d);     check("R10 unmapped reads 0", d, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        pin_i = '0; periph_out_i = '0; periph_oe_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_data_set_clear();
        t_direction();
        t_gpio_out();
        t_gpio_in();
        t_periph();
        t_ignored();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule